// File: doc/BRIEF.md
# Single-to-Double Precision Widening Converter

This block takes one 32-bit IEEE 754 single-precision operand per cycle and returns its 64-bit double-precision equivalent one clock later. It sits in a floating-point datapath where a narrow operand has to join a wide one. The 64-bit result leaves the block as two 32-bit halves, so that it can be written into a pair of 32-bit register slots.

Normal numbers, zeros and infinities widen without any loss. A subnormal single is renormalised into a double normal. When flush-to-zero is enabled, a subnormal is instead replaced by a zero of the same sign and an input-denormal flag is raised. A NaN keeps its sign and its payload bits, with the quiet bit forced on. When default-NaN mode is enabled, every NaN becomes the canonical double quiet NaN. A signalling NaN raises the invalid flag.

Top module: `s2d_widen`

## Requirements
- R1: After reset, out_valid, both result halves, inv_flag and den_flag are all zero.
- R2: A result appears exactly one cycle after the input is accepted: out_valid is in_valid delayed by one clock. When out_valid is low, inv_flag and den_flag are low.
- R3: A normal input keeps its sign. Its 8-bit exponent plus 896 becomes the 11-bit exponent, and its 23-bit fraction occupies double bits 51:29 with 29 zero bits below.
- R4: A zero or an infinity keeps its sign. Zero gives an all-zero exponent and fraction. Infinity gives exponent 0x7FF and a zero fraction.
- R5: With default-NaN off, a NaN input (exponent all ones, fraction nonzero) gives the following result: input bit 31 goes to bit 63, bits 62:51 are all ones, input bits 21:0 go to bits 50:29, and bits 28:0 are zero.
- R6: With default-NaN on, any NaN input gives 0x7FF8000000000000, whatever its sign and payload.
- R7: inv_flag is raised only for a signalling NaN, that is a NaN with input bit 22 clear. This holds in both NaN modes. A quiet NaN (bit 22 set) leaves inv_flag low.
- R8: With flush-to-zero off, a subnormal input (exponent zero, fraction nonzero) gives the exactly equal double normal value, and den_flag stays low.
- R9: With flush-to-zero on, a subnormal input gives a zero with the input's sign, and den_flag is raised.
- R10: Flush-to-zero has no effect on normal, zero, infinity or NaN inputs.
- R11: res_lo carries result bits 31:0 and res_hi carries result bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_bits | input | 32 | Single-precision operand |
| ftz_en | input | 1 | Flush subnormal inputs to signed zero |
| dnan_en | input | 1 | Replace every NaN with the default NaN |
| out_valid | output | 1 | Result present this cycle |
| res_lo | output | 32 | Double result bits 31:0 |
| res_hi | output | 32 | Double result bits 63:32 |
| inv_flag | output | 1 | Invalid operation (signalling NaN input) |
| den_flag | output | 1 | Input denormal was flushed |

## Verification
The result halves and both flags come from a single register stage. They are therefore due on the first rising edge after the operand is presented, and are valid for the whole of the following cycle. The driver places each operand on a falling edge and pushes the expected item into the queue at that moment. The monitor samples on each later falling edge, and pops one item whenever out_valid is high. Any output seen without a matching queued item, and any item left in the queue at the end, counts as an error. Explicit idle-cycle checks confirm that out_valid and the flags fall one cycle after in_valid drops.

// File: rtl/s2d_pkg.sv
package s2d_pkg;
  // operand class seen by the widening datapath
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;
endpackage

// File: rtl/s2d_classify.sv
module s2d_classify #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW-1:0]         exp_i,
  input  logic [MW-1:0]         frac_i,
  output s2d_pkg::fp_class_e    cls_o
);
  import s2d_pkg::*;

  logic exp_zero, exp_ones, frac_zero, quiet;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_ones  = (exp_i == {EW{1'b1}});
    frac_zero = (frac_i == '0);
    quiet     = frac_i[MW-1];
    if (exp_zero)
      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_ones)
      cls_o = frac_zero ? CLS_INF : (quiet ? CLS_QNAN : CLS_SNAN);
    else
      cls_o = CLS_NORM;
  end
endmodule

// File: rtl/s2d_subnorm_norm.sv
module s2d_subnorm_norm #(
  parameter int SMW   = 23,
  parameter int SBIAS = 127,
  parameter int DEW   = 11,
  parameter int DBIAS = 1023
) (
  input  logic [SMW-1:0] frac_i,
  output logic [DEW-1:0] exp_o,
  output logic [SMW-1:0] frac_o
);
  localparam int PW = $clog2(SMW) + 1;
  // exponent of a value whose leading one sits at bit 0 of the subnormal fraction
  localparam int EXP_BASE = DBIAS - SBIAS + 1 - SMW;

  logic [PW-1:0]    msb;
  logic [2*SMW-1:0] shifted;

  // position of the most significant set bit (later hits overwrite earlier)
  always_comb begin
    msb = '0;
    for (int i = 0; i < SMW; i++)
      if (frac_i[i]) msb = PW'(i);
  end

  always_comb begin
    shifted = {{SMW{1'b0}}, frac_i} << (PW'(SMW) - msb);
    frac_o  = shifted[SMW-1:0];
    exp_o   = DEW'(EXP_BASE) + DEW'(msb);
  end
endmodule

// File: rtl/s2d_widen.sv
module s2d_widen #(
  parameter int SEW   = 8,
  parameter int SMW   = 23,
  parameter int DEW   = 11,
  parameter int DMW   = 52
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  input  logic        ftz_en,
  input  logic        dnan_en,
  output logic        out_valid,
  output logic [31:0] res_lo,
  output logic [31:0] res_hi,
  output logic        inv_flag,
  output logic        den_flag
);
  import s2d_pkg::*;

  localparam int SW    = 1 + SEW + SMW;
  localparam int DW    = 1 + DEW + DMW;
  localparam int HW    = DW / 2;
  localparam int PAD   = DMW - SMW;
  localparam int SBIAS = (1 << (SEW - 1)) - 1;
  localparam int DBIAS = (1 << (DEW - 1)) - 1;
  localparam int REBIAS = DBIAS - SBIAS;

  logic            s_sign;
  logic [SEW-1:0]  s_exp;
  logic [SMW-1:0]  s_frac;
  fp_class_e       cls;
  logic [DEW-1:0]  n_exp;
  logic [SMW-1:0]  n_frac;
  logic [DW-1:0]   wide;
  logic            inv_nx, den_nx;
  logic [DW-1:0]   res_q;

  assign s_sign = in_bits[SW-1];
  assign s_exp  = in_bits[SW-2 -: SEW];
  assign s_frac = in_bits[SMW-1:0];

  s2d_classify #(.EW(SEW), .MW(SMW)) u_cls (
    .exp_i  (s_exp),
    .frac_i (s_frac),
    .cls_o  (cls)
  );

  s2d_subnorm_norm #(.SMW(SMW), .SBIAS(SBIAS), .DEW(DEW), .DBIAS(DBIAS)) u_norm (
    .frac_i (s_frac),
    .exp_o  (n_exp),
    .frac_o (n_frac)
  );

  always_comb begin
    inv_nx = 1'b0;
    den_nx = 1'b0;
    unique case (cls)
      CLS_ZERO: wide = {s_sign, {(DW-1){1'b0}}};
      CLS_INF:  wide = {s_sign, {DEW{1'b1}}, {DMW{1'b0}}};
      CLS_NORM: wide = {s_sign, DEW'(s_exp) + DEW'(REBIAS), s_frac, {PAD{1'b0}}};
      CLS_SUB: begin
        if (ftz_en) begin
          wide   = {s_sign, {(DW-1){1'b0}}};
          den_nx = 1'b1;
        end else begin
          wide = {s_sign, n_exp, n_frac, {PAD{1'b0}}};
        end
      end
      CLS_QNAN, CLS_SNAN: begin
        inv_nx = (cls == CLS_SNAN);
        if (dnan_en)
          wide = {1'b0, {(DEW+1){1'b1}}, {(DMW-1){1'b0}}};
        else
          wide = {s_sign, {(DEW+1){1'b1}}, s_frac[SMW-2:0], {PAD{1'b0}}};
      end
      default:  wide = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      inv_flag  <= 1'b0;
      den_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      inv_flag  <= in_valid & inv_nx;
      den_flag  <= in_valid & den_nx;
      if (in_valid) res_q <= wide;
    end
  end

  assign res_lo = res_q[HW-1:0];
  assign res_hi = res_q[DW-1:HW];

  // R2: output valid trails the input valid by one clock
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !inv_flag && !den_flag));
  // R7: a signalling NaN operand produces the invalid flag next cycle
  p_snan_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bits[30:23] == 8'hFF && in_bits[22:0] != '0 && !in_bits[22])
      |=> inv_flag);
  // R5: any invalid result carries an all-ones exponent plus quiet bit
  p_nan_shape_r5: assert property (@(posedge clk) disable iff (rst)
    inv_flag |-> (res_hi[30:19] == 12'hFFF));
  // R9: a flushed operand leaves only the sign bit
  p_flush_zero_r9: assert property (@(posedge clk) disable iff (rst)
    den_flag |-> (res_lo == '0 && res_hi[30:0] == '0));
  // R9/R7: the two flags never rise together
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(inv_flag && den_flag));
endmodule

// File: tb/s2d_widen_test.sv
`timescale 1ns/1ps
module s2d_widen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_bits;
  logic        ftz_en, dnan_en;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic        inv_flag, den_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [63:0] val;
    logic        inv;
    logic        den;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  s2d_widen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .ftz_en(ftz_en), .dnan_en(dnan_en), .out_valid(out_valid),
    .res_lo(res_lo), .res_hi(res_hi), .inv_flag(inv_flag), .den_flag(den_flag)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] x, input logic ftz, input logic dn,
                                 input string tag);
    exp_t r;
    logic        s   = x[31];
    logic [7:0]  e   = x[30:23];
    logic [22:0] f   = x[22:0];
    logic [23:0] m;
    int          ue;
    r.tag = tag; r.inv = 1'b0; r.den = 1'b0;
    if (e == 8'hFF && f != 0) begin
      r.inv = !f[22];
      if (dn) r.val = 64'h7FF8000000000000;
      else    r.val = {s, 12'hFFF, f[21:0], 29'b0};
    end else if (e == 8'hFF) begin
      r.val = {s, 11'h7FF, 52'b0};
    end else if (e == 0 && f == 0) begin
      r.val = {s, 63'b0};
    end else if (e == 0) begin
      if (ftz) begin
        r.val = {s, 63'b0};
        r.den = 1'b1;
      end else begin
        m  = {1'b0, f};
        ue = -126;
        while (!m[23]) begin m = m << 1; ue = ue - 1; end
        r.val = {s, 11'(ue + 1023), m[22:0], 29'b0};
      end
    end else begin
      r.val = {s, 11'(int'(e) - 127 + 1023), f, 29'b0};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [31:0] x, input logic ftz, input logic dn,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_bits = x; ftz_en = ftz; dnan_en = dn;
    sb_q.push_back(model(x, ftz, dn, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item for every valid result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected output", {res_hi, res_lo}, 64'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({res_hi, res_lo} === e.val, e.tag, {res_hi, res_lo}, e.val);
        check(inv_flag === e.inv, {e.tag, " R7 inv_flag"}, 64'(inv_flag), 64'(e.inv));
        check(den_flag === e.den, {e.tag, " R9 den_flag"}, 64'(den_flag), 64'(e.den));
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bits = '0; ftz_en = 1'b0; dnan_en = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && res_lo === '0 && res_hi === '0 &&
          inv_flag === 1'b0 && den_flag === 1'b0, "R1 reset state",
          {res_hi, res_lo}, 64'h0);
    rst = 1'b0;

    // R3 normals, R11 halves checked through the same comparison
    drive(32'h3F800000, 0, 0, "R3 one R11");
    drive(32'hC0200000, 0, 0, "R3 minus 2.5");
    drive(32'h7F7FFFFF, 0, 0, "R3 max normal");
    drive(32'h00800000, 0, 0, "R3 min normal");
    // R4 zeros and infinities
    drive(32'h00000000, 0, 0, "R4 +zero");
    drive(32'h80000000, 0, 0, "R4 -zero");
    drive(32'h7F800000, 0, 0, "R4 +inf");
    drive(32'hFF800000, 1, 0, "R4 -inf");
    // R5/R7 payload-preserving NaNs
    drive(32'h7FC00001, 0, 0, "R5 qnan");
    drive(32'hFF800001, 0, 0, "R5 R7 snan neg");
    drive(32'h7FBFFFFF, 0, 0, "R5 R7 snan full payload");
    // R6 default NaN
    drive(32'hFFC12345, 0, 1, "R6 qnan default");
    drive(32'hFF812345, 0, 1, "R6 R7 snan default");
    // R8 subnormals, flush off
    drive(32'h00000001, 0, 0, "R8 smallest sub");
    drive(32'h807FFFFF, 0, 0, "R8 largest sub neg");
    drive(32'h00012345, 0, 0, "R8 mid sub");
    // R9 flush on
    drive(32'h80000001, 1, 0, "R9 flush neg");
    drive(32'h00400000, 1, 0, "R9 flush pos");
    // R10 flush has no effect elsewhere
    drive(32'h3F800000, 1, 0, "R10 normal with ftz");
    drive(32'h7FC00003, 1, 0, "R10 nan with ftz");
    drive(32'h00000000, 1, 0, "R10 zero with ftz");
    idle(1);
    @(negedge clk);
    // one idle cycle after in_valid dropped: result stage must be empty
    check(out_valid === 1'b0 && inv_flag === 1'b0 && den_flag === 1'b0,
          "R2 idle after gap", 64'(out_valid), 64'h0);
    drive(32'hFF800001, 0, 0, "R2 R7 restart snan");
    idle(1);
    @(negedge clk);
    check(out_valid === 1'b0 && inv_flag === 1'b0, "R2 flag drops",
          64'(inv_flag), 64'h0);
    idle(2);
    check(sb_q.size() == 0, "R2 scoreboard drained", 64'(sb_q.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule